// File: doc/BRIEF.md
# Dual-Channel Angle Readout Port with Read Freeze

This block puts the angle words of two position-tracking channels onto one shared parallel bus. Each channel owns an up/down counter that follows its shaft one step at a time. The counters keep running whichever channel is selected and whether or not a read is under way, so conversion is never interrupted by a host access.

A host picks a channel with a select line and starts a read by pulling an active-low enable low. The block does not switch the selected counter straight onto the bus. A holding register sits between them. While no read has settled, this register follows the selected counter every clock. Once a programmable settle interval has run out, the register freezes and a valid flag rises. The word stays put until the enable is released or the select line moves, even if the counter steps meanwhile. The freeze is a clocked capture, so a word caught halfway between two counts never reaches the bus.

The three-state bus is modelled as a data value plus a separate drive enable. When the enable rises at the end of a read, a recovery window starts. A new read that begins inside this window has its settle countdown held until the window has passed. This gives fresh counts time to flow into the holding register before the next word is frozen.

Top module: `angle_pair_port`

## Requirements
- R1: With `sel_a` at 1 the bus presents channel A's counter. With `sel_a` at 0 it presents channel B's counter.
- R2: While `oe_n` is 1, `bus_drive` is 0, `bus_data` is all zeros and `data_valid` is 0. While `oe_n` is 0, `bus_drive` is 1.
- R3: On the first cycle with `oe_n` at 0, `bus_data` equals the selected counter's value at the preceding clock edge. Until the read settles, the word keeps following the selected counter with a lag of one edge.
- R4: While `data_valid` stays 1, `bus_data` does not change, even when the selected counter steps.
- R5: A fall of `oe_n` or a change of `sel_a` during a read restarts settling: `data_valid` is 0 at once and rises SETTLE+1 clock edges later if no recovery window is pending. `data_valid` is never 1 while `oe_n` is 1 or on the first cycle of a read.
- R6: The clock edge that first samples `oe_n` at 1 after a read loads a recovery window of GAP edges. Settling does not count down while this window is open. So a read that starts one cycle after the release waits SETTLE+GAP edges for `data_valid`.
- R7: On every clock edge, each counter whose step input is 1 moves by one: up when its direction input is 1, down when it is 0. It wraps modulo 2^WIDTH. This happens regardless of `sel_a` and `oe_n`.
- R8: Reset clears both counters and the holding register, so the first read after reset presents 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_a | input | 1 | Channel A count step this cycle |
| up_a | input | 1 | Channel A direction, 1 counts up |
| step_b | input | 1 | Channel B count step this cycle |
| up_b | input | 1 | Channel B direction, 1 counts up |
| sel_a | input | 1 | Channel select, 1 picks A and 0 picks B |
| oe_n | input | 1 | Active-low read enable |
| bus_data | output | WIDTH | Presented angle word, zero when not driven |
| bus_drive | output | 1 | Bus drive enable, the three-state control |
| data_valid | output | 1 | Presented word has settled and is frozen |

## Verification
On every cycle, the assertions check the following:
- the released-bus state;
- that a frozen word holds while valid stays up;
- that valid never shows with the enable high or on the first cycle of a read;
- that the first word of a read comes from the selected counter;
- that each counter steps exactly as its inputs ask.

The exact number of edges before valid rises, the longer wait caused by the recovery window, and the restart on a mid-read select change can only be seen in the bench's scenarios. The same holds for the proof that counting went on behind a frozen word. These are compared against a behavioural model on every clock.

// File: rtl/angle_pair_port.sv
`timescale 1ns/1ps
module angle_pair_port #(
  parameter int WIDTH  = 14,
  parameter int SETTLE = 4,
  parameter int GAP    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_a,
  input  logic             up_a,
  input  logic             step_b,
  input  logic             up_b,
  input  logic             sel_a,
  input  logic             oe_n,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_drive,
  output logic             data_valid
);
  localparam int SW = $clog2(SETTLE + 2);
  localparam int GW = $clog2(GAP + 2);
  localparam logic [SW-1:0] SET_LOAD = SW'(SETTLE);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_a, cnt_b, held, live;
  logic [SW-1:0]    settle;
  logic [GW-1:0]    gap;
  logic             valid_q, sel_q, oe_n_q, restart;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_a <= '0;
    else if (step_a) cnt_a <= up_a ? cnt_a + ONE : cnt_a - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_b <= '0;
    else if (step_b) cnt_b <= up_b ? cnt_b + ONE : cnt_b - ONE;
  end

  assign live    = sel_a ? cnt_a : cnt_b;
  assign restart = !oe_n && (oe_n_q || (sel_a != sel_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_n_q  <= 1'b1;
      sel_q   <= 1'b1;
      gap     <= '0;
      held    <= '0;
      settle  <= SET_LOAD;
      valid_q <= 1'b0;
    end else begin
      oe_n_q <= oe_n;
      sel_q  <= sel_a;
      if (oe_n && !oe_n_q) gap <= GAP_LOAD;
      else if (gap != '0)  gap <= gap - 1'b1;
      if (oe_n || restart) begin
        held    <= live;
        settle  <= SET_LOAD;
        valid_q <= 1'b0;
      end else if (!valid_q) begin
        held <= live;
        if (gap == '0) begin
          if (settle > SW'(1)) settle <= settle - 1'b1;
          else                 valid_q <= 1'b1;
        end
      end
    end
  end

  assign bus_drive  = !oe_n;
  assign bus_data   = oe_n ? '0 : held;
  assign data_valid = valid_q && !oe_n && (sel_a == sel_q);
endmodule

// File: rtl/angle_pair_port_chk.sv
`timescale 1ns/1ps
module angle_pair_port_chk #(
  parameter int WIDTH = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_a,
  input logic             up_a,
  input logic             step_b,
  input logic             up_b,
  input logic             sel_a,
  input logic             oe_n,
  input logic [WIDTH-1:0] bus_data,
  input logic             bus_drive,
  input logic             data_valid,
  input logic [WIDTH-1:0] cnt_a,
  input logic [WIDTH-1:0] cnt_b
);
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!bus_drive && bus_data == '0 && !data_valid));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && data_valid && $past(data_valid)) |-> bus_data == $past(bus_data));

  assert_first_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !oe_n && $past(oe_n)) |-> !data_valid);

  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !oe_n && $past(oe_n)) |->
      bus_data == ($past(sel_a) ? $past(cnt_a) : $past(cnt_b)));

  assert_count_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_a == $past(cnt_a) +
      ($past(step_a) ? ($past(up_a) ? WIDTH'(1) : {WIDTH{1'b1}}) : WIDTH'(0)));

  assert_count_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_b == $past(cnt_b) +
      ($past(step_b) ? ($past(up_b) ? WIDTH'(1) : {WIDTH{1'b1}}) : WIDTH'(0)));
endmodule

bind angle_pair_port angle_pair_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_a(step_a), .up_a(up_a), .step_b(step_b),
  .up_b(up_b), .sel_a(sel_a), .oe_n(oe_n), .bus_data(bus_data),
  .bus_drive(bus_drive), .data_valid(data_valid), .cnt_a(cnt_a), .cnt_b(cnt_b)
);

// File: tb/test_angle_pair_port.sv
`timescale 1ns/1ps
module test_angle_pair_port;
  localparam int W = 14, S = 4, G = 3;
  localparam int MASK = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic step_a = 0, up_a = 1, step_b = 0, up_b = 1, sel_a = 1, oe_n = 1;
  logic [W-1:0] bus_data;
  logic bus_drive, data_valid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  angle_pair_port #(.WIDTH(W), .SETTLE(S), .GAP(G)) i_angle_pair_port (
    .clk(clk), .rst_n(rst_n), .step_a(step_a), .up_a(up_a), .step_b(step_b),
    .up_b(up_b), .sel_a(sel_a), .oe_n(oe_n), .bus_data(bus_data),
    .bus_drive(bus_drive), .data_valid(data_valid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int ma, mb, mlat, mset, mgap, mval, prev_oe_n, prev_sel;
  always @(posedge clk) begin
    int sc, gnow;
    if (!rst_n) begin
      ma = 0; mb = 0; mlat = 0; mset = S; mgap = 0; mval = 0;
      prev_oe_n = 1; prev_sel = 1;
    end else begin
      sc = sel_a ? ma : mb;
      gnow = mgap;
      if (oe_n) begin
        mgap = (prev_oe_n == 0) ? G : (mgap > 0 ? mgap - 1 : 0);
        mlat = sc; mset = S; mval = 0;
      end else begin
        mgap = mgap > 0 ? mgap - 1 : 0;
        if (prev_oe_n == 1 || int'(sel_a) != prev_sel) begin
          mlat = sc; mset = S; mval = 0;
        end else if (mval == 0) begin
          mlat = sc;
          if (gnow == 0) begin
            if (mset > 1) mset--; else mval = 1;
          end
        end
      end
      if (step_a) ma = (ma + (up_a ? 1 : -1)) & MASK;
      if (step_b) mb = (mb + (up_b ? 1 : -1)) & MASK;
      prev_oe_n = oe_n; prev_sel = sel_a;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int ev;
      ev = (mval != 0 && !oe_n && int'(sel_a) == prev_sel) ? 1 : 0;
      check(bus_drive == !oe_n, "R2 model drive", bus_drive, !oe_n);
      check(int'(bus_data) == (oe_n ? 0 : mlat), "R4 model data", bus_data, oe_n ? 0 : mlat);
      check(int'(data_valid) == ev, "R5 model valid", data_valid, ev);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    #2;
    while (!data_valid && n < 40) begin
      @(negedge clk); #2; n++;
    end
  endtask

  bit finished = 0;
  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3); rst_n = 1;
    #2;
    check(!bus_drive && bus_data == 0 && !data_valid, "R8 reset idle", bus_data, 0);
    cyc(1); oe_n = 0; #2;
    check(bus_data == 0, "R8 first read after reset", bus_data, 0);
    check(bus_drive, "R2 drive when enabled", bus_drive, 1);
    cyc(1); oe_n = 1;
    cyc(G + 2);
    // R7 count A up five steps, R1 select A
    step_a = 1; up_a = 1; sel_a = 1;
    cyc(5); step_a = 0;
    cyc(1); oe_n = 0; #2;
    check(bus_data == 5, "R3 R1 first word channel A", bus_data, 5);
    check(!data_valid, "R5 not valid on first read cycle", data_valid, 0);
    wait_valid(n);
    check(n == S + 1, "R5 settle edges", n, S + 1);
    // R4 freeze while counter moves
    @(negedge clk); step_a = 1;
    for (int i = 0; i < 6; i++) begin
      #2; check(bus_data == 5 && data_valid, "R4 frozen word", bus_data, 5);
      @(negedge clk);
    end
    step_a = 0; oe_n = 1; #2;
    check(!bus_drive && bus_data == 0 && !data_valid, "R2 released", bus_data, 0);
    // R6 read inside recovery window
    @(negedge clk); oe_n = 0; #2;
    check(bus_data == 11, "R7 A kept counting during read", bus_data, 11);
    wait_valid(n);
    check(n == S + G, "R6 recovery delays valid", n, S + G);
    // channel B counts down through zero
    @(negedge clk); oe_n = 1; sel_a = 0; step_b = 1; up_b = 0;
    cyc(3); step_b = 0;
    cyc(G + 2); oe_n = 0; #2;
    check(bus_data == MASK - 2, "R7 R1 channel B wraps down", bus_data, MASK - 2);
    wait_valid(n);
    check(n == S + 1, "R5 settle on B", n, S + 1);
    // mid-read select change
    @(negedge clk); sel_a = 1; #2;
    check(!data_valid, "R5 select change drops valid", data_valid, 0);
    wait_valid(n);
    check(n == S + 1, "R5 restart after select change", n, S + 1);
    check(bus_data == 11, "R1 switched to channel A", bus_data, 11);
    // mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      step_a = $urandom_range(0, 1); up_a = $urandom_range(0, 1);
      step_b = $urandom_range(0, 1); up_b = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) sel_a = ~sel_a;
      if ($urandom_range(0, 7) == 0) oe_n = ~oe_n;
    end
    cyc(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule